// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a down-counting watchdog controlled through a byte-wide register port that has already been address-decoded. Software arms the watchdog by writing a two-byte key sequence to a key register and then writing a trigger bit. While the key sequence is open, software may also write a new preload value. The trigger copies the preload value into the counter and restarts the prescaler. Once enabled, the counter steps down once per prescaler tick. The tick is either every clock cycle or every 1024th cycle.

When the count runs out, an expiry flag and a sticky timeout status bit are set. If output enable is set, the active-low timeout pin is driven low, and it stays low until the next reload. A lock bit, once written, forces the timer on and freezes its configuration until a hard reset. The status and expiry flags sit in a separate always-on reset domain, so software can read why the chip restarted after an ordinary reset. The block carries no streaming data, so every pin is a plain control or status signal with no valid/ready handshake or back-pressure. Register reads are combinational from `reg_addr`.

Top module: `lwd_top`

## Requirements
- R1: After both resets, the registers read as follows: preload bytes at 0x00/0x01/0x02 read 0xFF/0xFF/0x0F; the count bytes at 0x08/0x09/0x0A read the same values; control (0x04) reads 0x00; status (0x05) reads 0x00; and `tout_n` is 1.
- R2: The reload sequence writes 0x80 to the key register 0x0C, then writes 0x86 to 0x0C, then writes to the trigger register 0x0D with bit 0 set. It loads the counter with the preload value on the trigger write's clock edge and closes the sequence.
- R3: Any write other than the expected next step returns the sequence to idle, so a later trigger write has no effect on the count. As an exception, writing 0x80 to 0x0C always re-arms the first step, and preload writes are allowed while the sequence is open.
- R4: Preload writes (20 bits: bits 7:0 at 0x00, bits 15:8 at 0x01, bits 19:16 at 0x02) are ignored unless the key sequence is open. While it is open they are accepted and keep it open.
- R5: With enable set (control bit 0), the count decreases by exactly one per prescaler tick. With enable clear, it holds its value.
- R6: With control bit 2 clear, the prescaler ticks every clock cycle. With it set, it ticks every 1024 cycles, counted from the later of the reload and the enable.
- R7: The count expires on the tick that takes it from 1 to 0, or on the first tick if it was loaded with 0. On expiry, status bit 0 (timeout) and status bit 1 (expired) are set. `tout_n` is low exactly when expired and output enable (control bit 1) are both set.
- R8: The expired flag and a low `tout_n` are held through further ticks and through a status clear. They end only on a reload or on an always-on reset.
- R9: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. Both status bits survive an ordinary reset (`rst_n`) and are cleared only by `aon_rst_n`.
- R10: Writing control bit 3 (lock) also sets enable. While locked, control writes are ignored and the control register keeps its value. Only `rst_n` clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset for configuration, counter and prescaler |
| aon_rst_n | input | 1 | Active-low reset of the always-on status domain |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 5 | Decoded register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| tout_n | output | 1 | Active-low timeout output |

## Verification
The main function is a sweep of preload values: every value from 0 to 20, plus values that carry into the middle byte. For each one the bench checks that `tout_n` is still high one cycle before the expected expiry and low exactly on it. This distinguishes off-by-one decrement and expiry-condition errors, and mistakes in loading the upper bytes. The slow prescaler is checked at cycles 1023/1024 and 2047/2048, which separates a wrong divider from a wrong restart point. Broken key sequences, a disable in mid-count, expiry with the output disabled, a status clear while expired, and separate pulses on the two resets each isolate one requirement.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] A_PRE0 = 5'h00;
  localparam logic [REG_AW-1:0] A_CTRL = 5'h04;
  localparam logic [REG_AW-1:0] A_STAT = 5'h05;
  localparam logic [REG_AW-1:0] A_CNT0 = 5'h08;
  localparam logic [REG_AW-1:0] A_KEY  = 5'h0C;
  localparam logic [REG_AW-1:0] A_TRIG = 5'h0D;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARMED, SEQ_OPEN} seq_e;

  typedef struct packed {
    logic lock;
    logic slow;
    logic oe;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/lwd_unlock.sv
module lwd_unlock
  import lwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              pre_hit,
  output logic              open_o,
  output logic              reload_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    reload_o = 1'b0;
    if (we) begin
      unique case (state_q)
        SEQ_IDLE: begin
          state_d = (addr == A_KEY && wdata == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
        end
        SEQ_ARMED: begin
          if (addr == A_KEY && wdata == KEY_SECOND)     state_d = SEQ_OPEN;
          else if (addr == A_KEY && wdata == KEY_FIRST) state_d = SEQ_ARMED;
          else                                          state_d = SEQ_IDLE;
        end
        SEQ_OPEN: begin
          if (pre_hit) state_d = SEQ_OPEN;
          else if (addr == A_TRIG && wdata[0]) begin
            reload_o = 1'b1;
            state_d  = SEQ_IDLE;
          end
          else if (addr == A_KEY && wdata == KEY_FIRST) state_d = SEQ_ARMED;
          else state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == SEQ_OPEN);

  // R3: the open state is never reached straight from idle
  p_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |=> (state_q != SEQ_OPEN));

  // R2: a reload always leaves the sequence closed
  p_reload_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |=> !open_o);
endmodule

// File: rtl/lwd_prescale.sv
module lwd_prescale #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (clr)     div_q <= '0;
    else if (run)     div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  assign tick = run && !clr && (!slow || div_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R6: in slow mode two ticks never fall on adjacent cycles
      p_slow_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && slow) |=> !tick || !slow);
    end
  endgenerate
endmodule

// File: rtl/lwd_counter.sv
module lwd_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         expired,
  output logic [W-1:0] cnt,
  output logic         fire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '1;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign fire = tick && !load && !expired && (cnt <= W'(1));

  // R5: no tick and no load leaves the count untouched
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

  // R5: a tick above zero lowers the count by exactly one
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lwd_aon_flags.sv
module lwd_aon_flags (
  input  logic clk,
  input  logic aon_rst_n,
  input  logic fire,
  input  logic rearm,
  input  logic clr_status,
  output logic status,
  output logic expired
);
  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) begin
      status  <= 1'b0;
      expired <= 1'b0;
    end else begin
      if (fire)            status <= 1'b1;
      else if (clr_status) status <= 1'b0;
      if (fire)            expired <= 1'b1;
      else if (rearm)      expired <= 1'b0;
    end
  end

  // R7: an expiry raises both flags on the next edge
  p_fire_sets_r7: assert property (@(posedge clk) disable iff (!aon_rst_n)
    fire |=> (status && expired));

  // R8: expired holds until a reload
  p_expired_hold_r8: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (expired && !rearm) |=> expired);
endmodule

// File: rtl/lwd_top.sv
module lwd_top
  import lwd_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int PRE_DIV = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aon_rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              tout_n
);
  localparam int NB = (CNT_W + 7) / 8;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       rd_pre [NB];
  logic [7:0]       rd_cnt [NB];
  logic             pre_hit, seq_open, reload, tick, fire, status, expired;

  always_comb begin
    pre_hit = 1'b0;
    for (int i = 0; i < NB; i++)
      if (reg_addr == REG_AW'(A_PRE0 + i)) pre_hit = 1'b1;
  end

  lwd_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pre_hit(pre_hit), .open_o(seq_open), .reload_o(reload)
  );

  // Preload slices, one per byte register; the top slice may be narrower
  generate
    for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam int LO = i * 8;
      localparam int HI = (LO + 8 > CNT_W) ? CNT_W - 1 : LO + 7;
      localparam int BW = HI - LO + 1;
      logic [BW-1:0] slice_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slice_q <= '1;
        else if (reg_we && seq_open && reg_addr == REG_AW'(A_PRE0 + i))
          slice_q <= reg_wdata[BW-1:0];
      end
      assign preload[HI:LO] = slice_q;
      assign rd_pre[i] = 8'(slice_q);
      assign rd_cnt[i] = 8'(cnt[HI:LO]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_we && reg_addr == A_CTRL && !ctrl_q.lock) begin
      ctrl_q.en   <= reg_wdata[0] | reg_wdata[3];
      ctrl_q.oe   <= reg_wdata[1];
      ctrl_q.slow <= reg_wdata[2];
      ctrl_q.lock <= reg_wdata[3];
    end
  end

  lwd_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .slow(ctrl_q.slow),
    .clr(reload), .tick(tick)
  );

  lwd_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(reload), .load_val(preload), .tick(tick),
    .expired(expired), .cnt(cnt), .fire(fire)
  );

  lwd_aon_flags u_aon (
    .clk(clk), .aon_rst_n(aon_rst_n), .fire(fire), .rearm(reload),
    .clr_status(reg_we && reg_addr == A_STAT && reg_wdata[0]),
    .status(status), .expired(expired)
  );

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == REG_AW'(A_PRE0 + i)) reg_rdata = rd_pre[i];
      if (reg_addr == REG_AW'(A_CNT0 + i)) reg_rdata = rd_cnt[i];
    end
    if (reg_addr == A_CTRL) reg_rdata = {4'b0, ctrl_q};
    if (reg_addr == A_STAT) reg_rdata = {6'b0, expired, status};
  end

  assign tout_n = !(expired && ctrl_q.oe);

  // R10: lock is sticky and keeps the timer running
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> ctrl_q.lock);
  p_lock_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |-> ctrl_q.en);

  // R2: a reload places the preload value in the counter
  p_reload_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(preload)));

  // R4: preload cannot move while the sequence is closed
  p_preload_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_open |=> $stable(preload));

  // R7: a low output implies the expiry flag
  p_tout_src_r7: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    !tout_n |-> expired);
endmodule

// File: tb/tb_lwd_top.sv
module tb_lwd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aon_rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tout_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lwd_top dut (
    .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tout_n(tout_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [4:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic unlock();
    wr(5'h0C, 8'h80);
    wr(5'h0C, 8'h86);
  endtask

  task automatic load(input int p);
    unlock();
    wr(5'h00, 8'(p));
    wr(5'h01, 8'(p >> 8));
    wr(5'h02, 8'(p >> 16));
    wr(5'h0D, 8'h01);
  endtask

  // R7 sweep body: fast ticks, output enabled, expiry at max(P,1) edges
  task automatic run_fast(input int p);
    int lat;
    lat = (p < 1) ? 1 : p;
    wr(5'h04, 8'h00);
    load(p);
    wr(5'h05, 8'h01);
    rdchk(5'h08, p & 8'hFF, "R2 count after reload");
    wr(5'h04, 8'h03);
    step(lat - 1);
    chk("R7 tout_n one cycle before expiry", int'(tout_n), 1);
    step(1);
    chk("R7 tout_n at expiry", int'(tout_n), 0);
    rdchk(5'h08, 0, "R7 count at expiry");
    rdchk(5'h05, 3, "R7 status at expiry");
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1; aon_rst_n = 1'b1;
    step(1);
    // R1 reset state
    rdchk(5'h00, 8'hFF, "R1 pre0");
    rdchk(5'h01, 8'hFF, "R1 pre1");
    rdchk(5'h02, 8'h0F, "R1 pre2");
    rdchk(5'h08, 8'hFF, "R1 cnt0");
    rdchk(5'h0A, 8'h0F, "R1 cnt2");
    rdchk(5'h04, 0, "R1 ctrl");
    rdchk(5'h05, 0, "R1 status");
    chk("R1 tout_n", int'(tout_n), 1);

    // R4 closed preload write ignored
    wr(5'h00, 8'h12);
    rdchk(5'h00, 8'hFF, "R4 preload closed");

    // R2 proper reload, R4 writes accepted while open
    load(5);
    rdchk(5'h00, 5, "R4 preload open");
    rdchk(5'h08, 5, "R2 count loaded");

    // R3 broken sequences
    unlock();
    wr(5'h00, 8'h09);
    wr(5'h05, 8'h00);
    wr(5'h0D, 8'h01);
    rdchk(5'h08, 5, "R3 interrupted after open");
    rdchk(5'h00, 9, "R4 write kept during open");
    wr(5'h0C, 8'h80);
    wr(5'h04, 8'h00);
    wr(5'h0C, 8'h86);
    wr(5'h0D, 8'h01);
    rdchk(5'h08, 5, "R3 interrupted between keys");
    wr(5'h0D, 8'h01);
    rdchk(5'h08, 5, "R3 trigger alone");
    wr(5'h0C, 8'h80);
    wr(5'h0C, 8'h80);
    wr(5'h0C, 8'h86);
    wr(5'h0D, 8'h01);
    rdchk(5'h08, 9, "R3 repeated first key re-arms");

    // R5 decrement and hold
    load(40);
    wr(5'h04, 8'h01);
    step(5);
    rdchk(5'h08, 35, "R5 decrement");
    wr(5'h04, 8'h00);
    rdchk(5'h08, 33, "R5 value at disable");
    step(5);
    rdchk(5'h08, 33, "R5 hold when disabled");

    // R7 sweep
    for (int p = 0; p <= 20; p++) run_fast(p);
    run_fast(256);
    run_fast(300);

    // R8 hold, R9 clear rules
    step(10);
    chk("R8 tout_n held", int'(tout_n), 0);
    wr(5'h05, 8'h00);
    rdchk(5'h05, 3, "R9 write 0 keeps status");
    wr(5'h05, 8'h01);
    rdchk(5'h05, 2, "R9 write 1 clears status");
    chk("R8 tout_n held after clear", int'(tout_n), 0);
    load(50);
    chk("R8 reload releases tout_n", int'(tout_n), 1);
    rdchk(5'h05, 0, "R8 expired cleared by reload");

    // R9 survive ordinary reset
    run_fast(3);
    pulse_rst();
    rdchk(5'h05, 3, "R9 status survives rst_n");
    rdchk(5'h04, 0, "R9 ctrl reset by rst_n");
    chk("R9 tout_n with oe reset", int'(tout_n), 1);
    @(negedge clk); aon_rst_n = 1'b0;
    step(2);
    aon_rst_n = 1'b1;
    rdchk(5'h05, 0, "R9 aon reset clears status");

    // R7 expiry with output disabled
    load(2);
    wr(5'h04, 8'h01);
    step(2);
    chk("R7 tout_n with oe off", int'(tout_n), 1);
    rdchk(5'h05, 3, "R7 status with oe off");

    // R6 slow prescaler
    wr(5'h04, 8'h00);
    load(2);
    wr(5'h04, 8'h07);
    step(1023);
    rdchk(5'h08, 2, "R6 before first slow tick");
    step(1);
    rdchk(5'h08, 1, "R6 first slow tick");
    step(1023);
    chk("R6 tout_n before second tick", int'(tout_n), 1);
    step(1);
    chk("R6 tout_n at second tick", int'(tout_n), 0);

    // R10 lock
    wr(5'h04, 8'h00);
    wr(5'h04, 8'h08);
    rdchk(5'h04, 8'h09, "R10 lock forces enable");
    wr(5'h04, 8'h00);
    rdchk(5'h04, 8'h09, "R10 disable ignored");
    wr(5'h04, 8'h06);
    rdchk(5'h04, 8'h09, "R10 config frozen");
    pulse_rst();
    rdchk(5'h04, 0, "R10 rst_n clears lock");

    // R1 always-on reset
    @(negedge clk); aon_rst_n = 1'b0;
    step(1);
    aon_rst_n = 1'b1;
    rdchk(5'h05, 0, "R1 status after aon reset");
    chk("R1 tout_n after resets", int'(tout_n), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule